// File: doc/BRIEF.md
# Bang-Bang Detector Noise Monitor

This block estimates oscillator noise in a digital clock loop from the one-bit output of a bang-bang phase-frequency detector, sampled once per reference clock. When the loop is noiseless and locked, the detector bit alternates between 0 and 1 on every reference cycle. When noise is present, the bit sometimes repeats. The monitor counts every reference cycle whose detector bit equals the bit before it, so a run of 1s counts and a run of 0s counts. It adds up these repeats over a programmable window.

At the close of each window the total is registered on the count output, together with a one-cycle valid strobe and two compare flags against a supplied noise reference. A noise-control loop uses these to steer the oscillator's noise setting. The count is an uncalibrated ratio measure. For the same noise, a larger limit-cycle amplitude in the loop, caused by a larger proportional gain, gives fewer repeats per window.

Top module: `bb_noise_monitor`

## Requirements
- R1: A sampled cycle counts as one noise event when `pdBit` equals the bit sampled on the previous enabled cycle. This holds for repeated 1s and for repeated 0s. Alternating bits add nothing.
- R2: The first enabled sample after reset, or after `enable` rises, only loads the previous-bit register and is never counted. With `winLen` = 1, that sample still ends a window, and the window reports a count of 0.
- R3: A window is `winLen` enabled cycles long. A value of 0 acts as 1. The end test compares the window position plus one against the live `winLen`. Windows follow one another with no gap: the first sample of a new window is compared with the last sample of the previous window.
- R4: The window's total, including an event on its last sample, appears on `noiseCnt` after the clock edge that takes the window's last sample. `cntValid` is high for exactly that following cycle. `noiseCnt` changes at no other time.
- R5: The event total saturates at 2^CNT_W-1 instead of wrapping.
- R6: `above` (total > `noiseRef`) and `below` (total < `noiseRef`) are registered on the same edge as `noiseCnt`, using `noiseRef` as sampled on that edge. An equal total raises neither flag, and the two flags are never high together.
- R7: While `enable` is low, nothing is sampled. The window position, the running total and the priming state are cleared, `cntValid` stays low, and `noiseCnt`, `above` and `below` keep their last values.
- R8: While `rstN` is low, `noiseCnt`, `cntValid`, `above` and `below` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one detector sample per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Sampling enable; low clears the window state |
| pdBit | input | 1 | Bang-bang detector output |
| winLen | input | WIN_W | Window length in reference cycles (0 acts as 1) |
| noiseRef | input | CNT_W | Noise reference the window total is compared against |
| noiseCnt | output | CNT_W | Event total of the most recent completed window |
| cntValid | output | 1 | One-cycle strobe when a new total is presented |
| above | output | 1 | Last total was greater than the reference |
| below | output | 1 | Last total was less than the reference |

## Verification
Wrong internal state shows at the ports by the end of the window it occurs in, and no later. A stale previous-bit register, a missed priming cycle or a lost cycle between windows moves the total by one on the next `cntValid` pulse. A window counter that is off by one moves the pulse by a cycle, so the cycle in which the pulse lands and the value that comes with it are both checked. A wrapping accumulator, or a compare against the wrong reference sample, becomes visible as a wrong total or wrong flags on the first window that reaches the limit or the reference.

// File: rtl/bbnm_pkg.sv
package bbnm_pkg;

  // Strobes passed from window control to the datapath each reference cycle
  typedef struct packed {
    logic clear;   // enable low: drop running total
    logic sample;  // take pdBit this cycle
    logic prime;   // first sample since enable/reset: load only, no event
    logic winEnd;  // this sample closes the window
  } ctrlStrobe_t;

endpackage

// File: rtl/bbnm_ctrl.sv
module bbnm_ctrl
  import bbnm_pkg::*;
#(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [WIN_W-1:0] winLen,
  output ctrlStrobe_t      strobe
);

  localparam int POS_W = WIN_W + 1;

  logic [WIN_W-1:0] winPos;
  logic             primed;
  logic [POS_W-1:0] posPlusOne;
  logic             lastSlot;

  // Live compare so a new length takes effect within the current window
  assign posPlusOne = {1'b0, winPos} + POS_W'(1);
  assign lastSlot   = posPlusOne >= {1'b0, winLen};

  always_comb begin
    strobe.clear  = !enable;
    strobe.sample = enable;
    strobe.prime  = enable && !primed;
    strobe.winEnd = enable && lastSlot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winPos <= '0;
      primed <= 1'b0;
    end else if (!enable) begin
      winPos <= '0;
      primed <= 1'b0;
    end else begin
      primed <= 1'b1;
      if (lastSlot) winPos <= '0;
      else          winPos <= winPos + WIN_W'(1);
    end
  end

endmodule

// File: rtl/bbnm_dp.sv
module bbnm_dp
  import bbnm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             pdBit,
  input  logic [CNT_W-1:0] noiseRef,
  output logic [CNT_W-1:0] noiseCnt,
  output logic             cntValid,
  output logic             above,
  output logic             below
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             prevBit;
  logic [CNT_W-1:0] acc;
  logic             isEvent;
  logic [CNT_W-1:0] accSum;

  // Repeat of the previous bit (either polarity) is one noise event
  assign isEvent = strobe.sample && !strobe.prime && (pdBit == prevBit);

  always_comb begin
    if (acc == CNT_MAX) accSum = CNT_MAX;
    else                accSum = acc + CNT_W'(isEvent);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBit  <= 1'b0;
      acc      <= '0;
      noiseCnt <= '0;
      cntValid <= 1'b0;
      above    <= 1'b0;
      below    <= 1'b0;
    end else begin
      if (strobe.sample) prevBit <= pdBit;

      if (strobe.clear || strobe.winEnd) acc <= '0;
      else if (strobe.sample)             acc <= accSum;

      cntValid <= strobe.winEnd;
      if (strobe.winEnd) begin
        noiseCnt <= accSum;
        above    <= accSum > noiseRef;
        below    <= accSum < noiseRef;
      end
    end
  end

endmodule

// File: rtl/bb_noise_monitor.sv
module bb_noise_monitor
  import bbnm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             pdBit,
  input  logic [WIN_W-1:0] winLen,
  input  logic [CNT_W-1:0] noiseRef,
  output logic [CNT_W-1:0] noiseCnt,
  output logic             cntValid,
  output logic             above,
  output logic             below
);

  ctrlStrobe_t strobe;

  bbnm_ctrl #(.WIN_W(WIN_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .winLen (winLen),
    .strobe (strobe)
  );

  bbnm_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pdBit    (pdBit),
    .noiseRef (noiseRef),
    .noiseCnt (noiseCnt),
    .cntValid (cntValid),
    .above    (above),
    .below    (below)
  );

endmodule

// File: rtl/bb_noise_monitor_chk.sv
module bb_noise_monitor_chk #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [WIN_W-1:0] winLen,
  input logic [CNT_W-1:0] noiseRef,
  input logic [CNT_W-1:0] noiseCnt,
  input logic             cntValid,
  input logic             above,
  input logic             below
);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !cntValid);

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(noiseCnt) |-> cntValid);

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(above && below));

  // R6
  above_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntValid |-> (above == (noiseCnt > $past(noiseRef))));

  // R6
  below_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntValid |-> (below == (noiseCnt < $past(noiseRef))));

  // R2
  prime_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(enable) && (winLen == WIN_W'(1))) |=> (cntValid && (noiseCnt == '0)));

endmodule

bind bb_noise_monitor bb_noise_monitor_chk #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .winLen   (winLen),
  .noiseRef (noiseRef),
  .noiseCnt (noiseCnt),
  .cntValid (cntValid),
  .above    (above),
  .below    (below)
);

// File: tb/bb_noise_monitor_tb.sv
`timescale 1ns/1ps
module bb_noise_monitor_tb;

  localparam int CNT_W = 6;
  localparam int WIN_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN;
  logic             enable;
  logic             pdBit;
  logic [WIN_W-1:0] winLen;
  logic [CNT_W-1:0] noiseRef;
  logic [CNT_W-1:0] noiseCnt;
  logic             cntValid;
  logic             above;
  logic             below;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state, built from the requirements
  bit mPrimed;
  bit mPrev;
  int mAcc;
  int mPos;
  int eCnt;
  bit eValid;
  bit eAbove;
  bit eBelow;

  always #5 clk = ~clk;

  bb_noise_monitor #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .pdBit(pdBit),
    .winLen(winLen), .noiseRef(noiseRef), .noiseCnt(noiseCnt),
    .cntValid(cntValid), .above(above), .below(below)
  );

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one reference cycle (called at a falling edge), then check after the rising edge
  task automatic step(input string req, input bit b, input bit en);
    int len;
    int sum;
    bit ev;
    pdBit  = b;
    enable = en;
    len = (winLen == 0) ? 1 : int'(winLen);
    if (!en) begin
      mPrimed = 0; mAcc = 0; mPos = 0; eValid = 0;
    end else begin
      ev  = mPrimed && (b == mPrev);
      sum = mAcc + int'(ev);
      if (sum > CMAX) sum = CMAX;
      if (mPos + 1 >= len) begin
        eValid = 1; eCnt = sum;
        eAbove = sum > int'(noiseRef);
        eBelow = sum < int'(noiseRef);
        mAcc = 0; mPos = 0;
      end else begin
        eValid = 0; mAcc = sum; mPos++;
      end
      mPrev = b; mPrimed = 1;
    end
    @(posedge clk); #1;
    checkVal(req, "cntValid", int'(cntValid), int'(eValid));
    checkVal(req, "noiseCnt", int'(noiseCnt), eCnt);
    checkVal(req, "above",    int'(above),    int'(eAbove));
    checkVal(req, "below",    int'(below),    int'(eBelow));
    @(negedge clk);
  endtask

  task automatic idle(input string req);
    step(req, 1'b0, 1'b0);
  endtask

  task automatic testReset();
    rstN = 0; enable = 0; pdBit = 0; winLen = 8; noiseRef = 0;
    mPrimed = 0; mPrev = 0; mAcc = 0; mPos = 0;
    eCnt = 0; eValid = 0; eAbove = 0; eBelow = 0;
    repeat (3) @(posedge clk);
    #1;
    checkVal("R8", "noiseCnt", int'(noiseCnt), 0);
    checkVal("R8", "cntValid", int'(cntValid), 0);
    checkVal("R8", "above", int'(above), 0);
    checkVal("R8", "below", int'(below), 0);
    @(negedge clk);
    rstN = 1;
    idle("R8");
  endtask

  task automatic testAlternate();
    // no repeats: count 0, equal to ref 0 -> neither flag
    winLen = 8; noiseRef = 0;
    for (int i = 0; i < 16; i++) step("R1", i[0], 1'b1);
    checkVal("R6", "equal no flags", int'(above | below), 0);
    idle("R1");
  endtask

  task automatic testRunOnes();
    // first window 7 events (priming), second 8 (no lost cycle)
    winLen = 8; noiseRef = 5;
    for (int i = 0; i < 16; i++) step("R3", 1'b1, 1'b1);
    checkVal("R3", "second window total", int'(noiseCnt), 8);
    idle("R3");
  endtask

  task automatic testRunZeros();
    winLen = 6; noiseRef = 20;
    for (int i = 0; i < 12; i++) step("R1", 1'b0, 1'b1);
    checkVal("R6", "below flag", int'(below), 1);
    idle("R1");
  endtask

  task automatic testMixed();
    // pattern with some repeats, reference changed mid-run
    logic [23:0] pat = 24'b1100_1010_0110_1011_0010_1101;
    winLen = 8; noiseRef = 2;
    for (int i = 0; i < 24; i++) begin
      if (i == 12) noiseRef = 3;
      step("R6", pat[i], 1'b1);
    end
    idle("R6");
  endtask

  task automatic testSaturate();
    winLen = 100; noiseRef = CNT_W'(CMAX);
    for (int i = 0; i < 100; i++) step("R5", 1'b1, 1'b1);
    checkVal("R5", "saturated total", int'(noiseCnt), CMAX);
    idle("R5");
  endtask

  task automatic testEnableDrop();
    winLen = 8; noiseRef = 4;
    for (int i = 0; i < 5; i++) step("R7", 1'b1, 1'b1);
    idle("R7");
    idle("R7");
    for (int i = 0; i < 8; i++) step("R2", 1'b1, 1'b1);
    checkVal("R2", "restart total", int'(noiseCnt), 7);
    idle("R7");
  endtask

  task automatic testShortWindow();
    winLen = 1; noiseRef = 0;
    step("R2", 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step("R4", (i % 4) < 2, 1'b1);
    winLen = 0;
    for (int i = 0; i < 6; i++) step("R3", 1'b0, 1'b1);
    winLen = 3;
    for (int i = 0; i < 7; i++) step("R4", i[1], 1'b1);
    idle("R4");
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testAlternate();
    testRunOnes();
    testRunZeros();
    testMixed();
    testSaturate();
    testEnableDrop();
    testShortWindow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule